// File: doc/BRIEF.md
# Cartridge Bank Register File

This block sits on the cartridge side of an 8-bit CPU bus and holds the banking state of a game cartridge controller. CPU writes into the upper half of the address space land in registers that choose which 8 KB program bank appears in each CPU window, which 1 KB pattern bank appears in each of the eight video windows, and how the nametables are mirrored. The same block turns each CPU address and each video pattern address into a physical memory address, one clock later, so that the ROM and RAM devices behind it can be driven directly.

Pattern bank numbers are 12 bits wide and are assembled from 4-bit pieces. A write chooses one of eight slots from a scrambled combination of address bits, and address bit 2 chooses which piece of that slot is loaded. Two bank values, 4 and 5, do not reach the pattern ROM at all: they select one of two 1 KB pages of a small on-cartridge pattern RAM. Two CPU windows are switchable, the two highest are tied to the last two banks of the program ROM for whatever ROM size the parameters give, and the 6000h–7FFFh window is routed to an 8 KB work RAM.

Top module: `cart_bank_regs`

## Requirements
- R1: A CPU write with cpu_wr high to any address from B000h to E00Ch inclusive updates pattern slot ((A13,A12,A11 or A3) as a 3-bit number + 2) mod 8, so B000h, B008h, C000h, C008h, D000h, D008h, E000h, E008h reach slots 0 to 7; the slot used for a video lookup is ppu_addr[12:10].
- R2: Such a write with address bit 2 clear replaces bits 3:0 of the slot's 12-bit bank number with cpu_data[3:0] and leaves bits 11:4 unchanged.
- R3: Such a write with address bit 2 set replaces bank bits 7:4 with cpu_data[3:0] and bank bits 11:8 with cpu_data[7:4], leaving bits 3:0 unchanged.
- R4: When the selected slot holds bank number 4 or 5, chr_ram_sel is 1, chr_ram_addr is {bank bit 0, ppu_addr[9:0]} and chr_rom_addr is 0; otherwise chr_ram_sel is 0, chr_ram_addr is 0 and chr_rom_addr is {bank, ppu_addr[9:0]}.
- R5: A write to exactly 8010h stores cpu_data as the bank for window 8000h–9FFFh, and a write to exactly A010h stores it as the bank for window A000h–BFFFh; the low PRG_BANK_W bits are used.
- R6: Window C000h–DFFFh always uses bank 2^PRG_BANK_W − 2 and window E000h–FFFFh always uses bank 2^PRG_BANK_W − 1; for any address of 8000h or above prg_rom_sel is 1 and prg_rom_addr is {bank, cpu_addr[12:0]}, else both are 0.
- R7: For cpu_addr in 6000h–7FFFh, wram_sel is 1 and wram_addr is cpu_addr[12:0]; elsewhere both are 0, and below 6000h neither select is 1.
- R8: A write to exactly 9400h stores cpu_data[1:0] as mirror_mode (0 vertical, 1 horizontal, 2 single-screen first page, 3 single-screen second page), visible from the clock edge that takes the write.
- R9: Writes to any other address, and any cycle with cpu_wr low, change no bank or mirroring state.
- R10: A synchronous active-high reset clears every bank number, both switchable program banks, mirror_mode and all address and select outputs to 0.
- R11: The address and select outputs are registered: they reflect the inputs and the bank state as they stood at the previous clock edge, before any write taken at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one write per cycle when high |
| ppu_addr | input | 13 | Video pattern address (0000h–1FFFh) |
| prg_rom_sel | output | 1 | Program ROM selected |
| prg_rom_addr | output | PRG_BANK_W+13 | Physical program ROM address |
| wram_sel | output | 1 | Work RAM selected |
| wram_addr | output | 13 | Work RAM address |
| chr_ram_sel | output | 1 | Pattern RAM selected instead of pattern ROM |
| chr_rom_addr | output | CHR_ROM_W+10 | Physical pattern ROM address |
| chr_ram_addr | output | 11 | Pattern RAM address |
| mirror_mode | output | 2 | Nametable mirroring mode |

## Verification
The assertions take for granted that reset is held for at least one clock before the block runs, and that cpu_addr, cpu_wr and ppu_addr carry known values on every edge, since the latency and hold properties compare present outputs with the previous cycle's inputs. The stimulus changes inputs only on the falling edge, always drives defined values, starts with several cycles of reset and applies a second reset in mid-run, so every property is evaluated only on cycles whose history lies after reset. Random traffic is biased towards the slot, bank and mirroring addresses and the edges of the B000h–E00Ch range so that the nibble assembly and the RAM redirection are hit often.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  localparam int CHR_SLOTS  = 8;
  localparam int CHR_BANK_W = 12;

  localparam logic [15:0] CHR_WIN_LO = 16'hB000;
  localparam logic [15:0] CHR_WIN_HI = 16'hE00C;
  localparam logic [15:0] PRG0_ADDR  = 16'h8010;
  localparam logic [15:0] PRG1_ADDR  = 16'hA010;
  localparam logic [15:0] MIR_ADDR   = 16'h9400;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;

  typedef struct packed {
    logic [3:0] hi;
    logic [7:0] lo;
  } chr_bank_t;

  // Slot decode for the pattern bank write range
  function automatic logic [2:0] chr_slot(input logic [15:0] a);
    return {a[13:12], a[11] | a[3]} + 3'd2;
  endfunction

endpackage

// File: rtl/cbr_chr_regs.sv
module cbr_chr_regs
  import cbr_pkg::*;
#(
  parameter int SLOTS = CHR_SLOTS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [15:0]           addr,
  input  logic [7:0]            data,
  output chr_bank_t [SLOTS-1:0] banks
);

  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  chr_bank_t bank_q [SLOTS];
  logic      in_win;
  logic [2:0] slot;

  assign in_win = wr_en && (addr >= CHR_WIN_LO) && (addr <= CHR_WIN_HI);
  assign slot   = chr_slot(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) bank_q[s] <= '0;
    end else if (in_win) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (SLOT_W'(slot) == SLOT_W'(s)) begin
          if (addr[2]) begin
            bank_q[s].lo[7:4] <= data[3:0];
            bank_q[s].hi      <= data[7:4];
          end else begin
            bank_q[s].lo[3:0] <= data[3:0];
          end
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_out
      assign banks[g] = bank_q[g];
    end
  endgenerate

endmodule

// File: rtl/cbr_chr_map.sv
module cbr_chr_map
  import cbr_pkg::*;
#(
  parameter int SLOTS     = CHR_SLOTS,
  parameter int CHR_ROM_W = CHR_BANK_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  chr_bank_t [SLOTS-1:0] banks,
  input  logic [12:0]           ppu_addr,
  output logic                  chr_ram_sel,
  output logic [CHR_ROM_W+9:0]  chr_rom_addr,
  output logic [10:0]           chr_ram_addr
);

  chr_bank_t cur;
  logic      is_ram;

  assign cur    = banks[ppu_addr[12:10]];
  // Bank numbers 4 and 5 differ only in bit 0
  assign is_ram = (cur[CHR_BANK_W-1:1] == 11'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_ram_sel  <= 1'b0;
      chr_rom_addr <= '0;
      chr_ram_addr <= '0;
    end else begin
      chr_ram_sel  <= is_ram;
      chr_ram_addr <= is_ram ? {cur.lo[0], ppu_addr[9:0]} : 11'd0;
      chr_rom_addr <= is_ram ? '0 : {cur[CHR_ROM_W-1:0], ppu_addr[9:0]};
    end
  end

endmodule

// File: rtl/cbr_prg_map.sv
module cbr_prg_map
  import cbr_pkg::*;
#(
  parameter int PRG_BANK_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [15:0]           addr,
  input  logic [7:0]            data,
  output logic                  prg_rom_sel,
  output logic [PRG_BANK_W+12:0] prg_rom_addr,
  output logic                  wram_sel,
  output logic [12:0]           wram_addr
);

  localparam logic [PRG_BANK_W-1:0] LAST_BANK   = '1;
  localparam logic [PRG_BANK_W-1:0] PENULT_BANK = LAST_BANK - PRG_BANK_W'(1);

  logic [7:0]            prg0_q, prg1_q;
  logic [PRG_BANK_W-1:0] win_bank;
  logic                  in_wram;

  always_ff @(posedge clk) begin
    if (rst) begin
      prg0_q <= '0;
      prg1_q <= '0;
    end else if (wr_en) begin
      if (addr == PRG0_ADDR) prg0_q <= data;
      if (addr == PRG1_ADDR) prg1_q <= data;
    end
  end

  always_comb begin
    case (addr[14:13])
      2'd0:    win_bank = prg0_q[PRG_BANK_W-1:0];
      2'd1:    win_bank = prg1_q[PRG_BANK_W-1:0];
      2'd2:    win_bank = PENULT_BANK;
      default: win_bank = LAST_BANK;
    endcase
  end

  assign in_wram = (addr[15:13] == 3'b011);

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_rom_sel  <= 1'b0;
      prg_rom_addr <= '0;
      wram_sel     <= 1'b0;
      wram_addr    <= '0;
    end else begin
      prg_rom_sel  <= addr[15];
      prg_rom_addr <= addr[15] ? {win_bank, addr[12:0]} : '0;
      wram_sel     <= in_wram;
      wram_addr    <= in_wram ? addr[12:0] : 13'd0;
    end
  end

endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cbr_pkg::*;
#(
  parameter int PRG_BANK_W = 5,
  parameter int CHR_ROM_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [15:0]            cpu_addr,
  input  logic [7:0]             cpu_data,
  input  logic                   cpu_wr,
  input  logic [12:0]            ppu_addr,
  output logic                   prg_rom_sel,
  output logic [PRG_BANK_W+12:0] prg_rom_addr,
  output logic                   wram_sel,
  output logic [12:0]            wram_addr,
  output logic                   chr_ram_sel,
  output logic [CHR_ROM_W+9:0]   chr_rom_addr,
  output logic [10:0]            chr_ram_addr,
  output logic [1:0]             mirror_mode
);

  chr_bank_t [CHR_SLOTS-1:0] banks;
  mirror_e                   mir_q;

  cbr_chr_regs #(.SLOTS(CHR_SLOTS)) u_chr_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cpu_wr),
    .addr  (cpu_addr),
    .data  (cpu_data),
    .banks (banks)
  );

  cbr_chr_map #(.SLOTS(CHR_SLOTS), .CHR_ROM_W(CHR_ROM_W)) u_chr_map (
    .clk          (clk),
    .rst          (rst),
    .banks        (banks),
    .ppu_addr     (ppu_addr),
    .chr_ram_sel  (chr_ram_sel),
    .chr_rom_addr (chr_rom_addr),
    .chr_ram_addr (chr_ram_addr)
  );

  cbr_prg_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg_map (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (cpu_wr),
    .addr         (cpu_addr),
    .data         (cpu_data),
    .prg_rom_sel  (prg_rom_sel),
    .prg_rom_addr (prg_rom_addr),
    .wram_sel     (wram_sel),
    .wram_addr    (wram_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) mir_q <= MIR_VERT;
    else if (cpu_wr && (cpu_addr == MIR_ADDR)) mir_q <= mirror_e'(cpu_data[1:0]);
  end

  assign mirror_mode = mir_q;

endmodule

// File: rtl/cart_bank_regs_chk.sv
module cart_bank_regs_chk #(
  parameter int PRG_BANK_W = 5,
  parameter int CHR_ROM_W  = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic [15:0]            cpu_addr,
  input logic [7:0]             cpu_data,
  input logic                   cpu_wr,
  input logic [12:0]            ppu_addr,
  input logic                   prg_rom_sel,
  input logic [PRG_BANK_W+12:0] prg_rom_addr,
  input logic                   wram_sel,
  input logic [12:0]            wram_addr,
  input logic                   chr_ram_sel,
  input logic [CHR_ROM_W+9:0]   chr_rom_addr,
  input logic [10:0]            chr_ram_addr,
  input logic [1:0]             mirror_mode
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R7
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> $onehot0({wram_sel, prg_rom_sel}));

  // R7
  wram_window_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (wram_sel == ($past(cpu_addr[15:13]) == 3'b011)));

  // R6
  last_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(cpu_addr[15:13]) == 3'b111) |->
      (prg_rom_addr[PRG_BANK_W+12:13] == {PRG_BANK_W{1'b1}}));

  // R4
  chr_ram_page_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && chr_ram_sel) |->
      (chr_ram_addr[9:0] == $past(ppu_addr[9:0]) && chr_rom_addr == '0));

  // R8
  mirror_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(cpu_wr && cpu_addr == 16'h9400)) |-> $stable(mirror_mode));

  // R11
  prg_latency_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (prg_rom_sel == $past(cpu_addr[15])));

endmodule

bind cart_bank_regs cart_bank_regs_chk #(
  .PRG_BANK_W(PRG_BANK_W),
  .CHR_ROM_W (CHR_ROM_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_addr     (cpu_addr),
  .cpu_data     (cpu_data),
  .cpu_wr       (cpu_wr),
  .ppu_addr     (ppu_addr),
  .prg_rom_sel  (prg_rom_sel),
  .prg_rom_addr (prg_rom_addr),
  .wram_sel     (wram_sel),
  .wram_addr    (wram_addr),
  .chr_ram_sel  (chr_ram_sel),
  .chr_rom_addr (chr_rom_addr),
  .chr_ram_addr (chr_ram_addr),
  .mirror_mode  (mirror_mode)
);

// File: tb/cart_bank_regs_tb.sv
`timescale 1ns/1ps
module cart_bank_regs_tb;

  localparam int PB = 5;
  localparam int CB = 12;
  localparam int NB = 1 << PB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [12:0] ppu_addr = '0;

  logic           prg_rom_sel;
  logic [PB+12:0] prg_rom_addr;
  logic           wram_sel;
  logic [12:0]    wram_addr;
  logic           chr_ram_sel;
  logic [CB+9:0]  chr_rom_addr;
  logic [10:0]    chr_ram_addr;
  logic [1:0]     mirror_mode;

  cart_bank_regs #(.PRG_BANK_W(PB), .CHR_ROM_W(CB)) u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_rom_sel(prg_rom_sel),
    .prg_rom_addr(prg_rom_addr), .wram_sel(wram_sel), .wram_addr(wram_addr),
    .chr_ram_sel(chr_ram_sel), .chr_rom_addr(chr_rom_addr),
    .chr_ram_addr(chr_ram_addr), .mirror_mode(mirror_mode)
  );

  always #2 clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  string req = "R10";

  // Behavioural model state
  int m_lo[8];
  int m_hi[8];
  int m_prg0, m_prg1, m_mir;
  int e_prg_sel, e_prg_addr, e_wram_sel, e_wram_addr;
  int e_chr_sel, e_chr_rom, e_chr_ram, e_mir;
  bit e_valid = 0;

  always @(posedge clk) begin
    int a, v, pa, slot, bank, bk, idx;
    a = int'(cpu_addr); v = int'(cpu_data); pa = int'(ppu_addr);
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
      m_prg0 = 0; m_prg1 = 0; m_mir = 0;
      e_prg_sel = 0; e_prg_addr = 0; e_wram_sel = 0; e_wram_addr = 0;
      e_chr_sel = 0; e_chr_rom = 0; e_chr_ram = 0; e_mir = 0;
    end else begin
      e_prg_sel = 0; e_prg_addr = 0; e_wram_sel = 0; e_wram_addr = 0;
      if (a >= 32768) begin
        case ((a - 32768) / 8192)
          0: bk = m_prg0;
          1: bk = m_prg1;
          2: bk = NB - 2;
          default: bk = NB - 1;
        endcase
        e_prg_sel = 1; e_prg_addr = (bk % NB) * 8192 + a % 8192;
      end else if (a >= 24576) begin
        e_wram_sel = 1; e_wram_addr = a - 24576;
      end
      slot = pa / 1024;
      bank = m_hi[slot] * 256 + m_lo[slot];
      if (bank == 4 || bank == 5) begin
        e_chr_sel = 1; e_chr_ram = (bank % 2) * 1024 + pa % 1024; e_chr_rom = 0;
      end else begin
        e_chr_sel = 0; e_chr_ram = 0; e_chr_rom = bank * 1024 + pa % 1024;
      end
      if (cpu_wr) begin
        if (a >= 45056 && a <= 57356) begin
          idx = ((((a & 8) | (a >> 8)) >> 3) + 2) & 7;
          if ((a & 4) != 0) begin
            m_lo[idx] = (m_lo[idx] & 15) | ((v & 15) << 4);
            m_hi[idx] = v >> 4;
          end else begin
            m_lo[idx] = (m_lo[idx] & 240) | (v & 15);
          end
        end else if (a == 32784) m_prg0 = v;
        else if (a == 40976) m_prg1 = v;
        else if (a == 37888) m_mir = v & 3;
      end
      e_mir = m_mir;
    end
    e_valid = 1;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic w, input logic [12:0] p);
    @(negedge clk);
    if (e_valid) begin
      chk("prg_rom_sel",  32'(prg_rom_sel),  32'(e_prg_sel));
      chk("prg_rom_addr", 32'(prg_rom_addr), 32'(e_prg_addr));
      chk("wram_sel",     32'(wram_sel),     32'(e_wram_sel));
      chk("wram_addr",    32'(wram_addr),    32'(e_wram_addr));
      chk("chr_ram_sel",  32'(chr_ram_sel),  32'(e_chr_sel));
      chk("chr_rom_addr", 32'(chr_rom_addr), 32'(e_chr_rom));
      chk("chr_ram_addr", 32'(chr_ram_addr), 32'(e_chr_ram));
      chk("mirror_mode",  32'(mirror_mode),  32'(e_mir));
    end
    cpu_addr = a; cpu_data = d; cpu_wr = w; ppu_addr = p;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    step(a, d, 1'b1, ppu_addr);
  endtask

  task automatic sweep();
    for (int s = 0; s < 8; s++) step(16'h4000 + 16'(s * 4096), 8'h00, 1'b0, 13'(s * 1024 + s * 37));
    step(16'h0000, 8'h00, 1'b0, 13'h1FFF);
  endtask

  logic [15:0] bases [8] = '{16'hB000, 16'hB008, 16'hC000, 16'hC008,
                             16'hD000, 16'hD008, 16'hE000, 16'hE008};

  initial begin
    // R10: reset state
    req = "R10";
    rst = 1'b1;
    repeat (4) step(16'h8000, 8'h00, 1'b0, 13'h0000);
    rst = 1'b0;
    sweep();

    // R1, R2: low nibble into each slot, upper data bits ignored
    req = "R1";
    for (int i = 0; i < 8; i++) wr(bases[i], 8'hA0 | 8'(i + 8));
    sweep();
    // R3: upper nibble of low byte plus high bits
    req = "R3";
    for (int i = 0; i < 8; i++) wr(bases[i] | 16'h0004, {4'(i + 1), 4'(15 - i)});
    sweep();
    // R2: low nibble rewrite keeps bits 11:4
    req = "R2";
    for (int i = 0; i < 8; i++) wr(bases[i], 8'hF0 | 8'(i));
    sweep();
    // R1: other addresses inside the range decode into slots too
    req = "R1";
    wr(16'hB7F4, 8'h21); wr(16'hDA83, 8'h07); wr(16'hE00C, 8'h5C); wr(16'hCFF0, 8'h0E);
    sweep();

    // R4: values 4 and 5 redirect to pattern RAM
    req = "R4";
    wr(16'hB004, 8'h00); wr(16'hB000, 8'h04);
    wr(16'hB00C, 8'h00); wr(16'hB008, 8'h05);
    wr(16'hC004, 8'h10); wr(16'hC000, 8'h04);
    wr(16'hC00C, 8'h00); wr(16'hC008, 8'h06);
    wr(16'hD004, 8'h00); wr(16'hD000, 8'h05);
    sweep();
    for (int k = 0; k < 12; k++) step(16'h0000, 8'h00, 1'b0, 13'(k * 613));

    // R5: switchable program banks
    req = "R5";
    wr(16'h8010, 8'h07); wr(16'hA010, 8'h2B);
    step(16'h8000, 0, 0, 0); step(16'h9FFF, 0, 0, 0);
    step(16'hA000, 0, 0, 0); step(16'hBFFF, 0, 0, 0);
    wr(16'h8010, 8'hFF);
    step(16'h8123, 0, 0, 0); step(16'h0000, 0, 0, 0);

    // R6: fixed windows
    req = "R6";
    step(16'hC000, 0, 0, 0); step(16'hDFFF, 0, 0, 0);
    step(16'hE000, 0, 0, 0); step(16'hFFFF, 0, 0, 0); step(16'h0000, 0, 0, 0);

    // R7: work RAM window edges
    req = "R7";
    step(16'h5FFF, 0, 0, 0); step(16'h6000, 0, 0, 0);
    step(16'h7FFF, 0, 0, 0); step(16'h0000, 0, 0, 0); step(16'h0000, 0, 0, 0);

    // R8: mirroring modes
    req = "R8";
    wr(16'h9400, 8'hFE); step(0, 0, 0, 0);
    wr(16'h9400, 8'h01); step(0, 0, 0, 0);
    wr(16'h9400, 8'hFF); step(0, 0, 0, 0);
    wr(16'h9400, 8'h00); step(0, 0, 0, 0);
    wr(16'h9400, 8'h02); step(0, 0, 0, 0);

    // R9: ignored writes
    req = "R9";
    wr(16'h8000, 8'h11); wr(16'h8011, 8'h12); wr(16'h9401, 8'h03);
    wr(16'hA000, 8'h13); wr(16'hF000, 8'h14); wr(16'hF008, 8'h03);
    wr(16'hE00D, 8'h15); wr(16'hAFFF, 8'h16); wr(16'h6000, 8'h17);
    step(16'h8010, 8'h1F, 1'b0, 0); step(16'hB000, 8'h33, 1'b0, 0);
    step(16'h9400, 8'h03, 1'b0, 0);
    sweep();
    step(16'h8000, 0, 0, 0); step(16'hA000, 0, 0, 0);

    // R11: random traffic against the cycle model
    req = "R11";
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      case ($urandom % 6)
        0: a = bases[$urandom % 8] | 16'(($urandom % 2) * 4);
        1: a = 16'h8010;
        2: a = 16'hA010;
        3: a = 16'h9400;
        4: a = 16'($urandom);
        default: a = 16'hB000 + 16'($urandom % 16'h300D);
      endcase
      step(a, 8'($urandom), 1'($urandom % 2), 13'($urandom));
    end

    // R10: reset in mid-run
    req = "R10";
    rst = 1'b1;
    step(16'hE000, 8'h00, 1'b0, 13'h0400);
    step(16'h9400, 8'h03, 1'b1, 13'h0400);
    rst = 1'b0;
    sweep();
    step(16'h8000, 0, 0, 0); step(16'hA000, 0, 0, 0); step(16'h0000, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL R11 watchdog: actual running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule